// File: doc/BRIEF.md
# Ternary-Symbol Sequence Recognizer

This block watches a stream of base-3 symbols, one per clock cycle, and raises a single detect flag when the accepted symbols end in either of two patterns. The short pattern is two zeros in a row. The long pattern is a two, then a one, then a zero. Matches may overlap. The zero that ends one match can also be the first zero of the next match.

A symbol counts only when its valid strobe is high. Symbols are carried on a two-bit code, and the one code that names no symbol is treated as illegal. Internally a four-state machine follows the recent history: nothing useful seen, last symbol zero, last symbol two, and last two symbols two-one. This is the smallest machine that tells both patterns apart. The detect flag is a Mealy output, so it rises in the same cycle as the symbol that completes a match.

Top module: `ternary_seq_detector`

## Requirements
- R1: While synchronous reset is high, detect is low. After reset the machine holds no history, so a first accepted 0 does not detect.
- R2: Detect is high in the cycle of an accepted symbol 0 when the two accepted symbols before it were 2 and then 1.
- R3: Detect is high in the cycle of an accepted symbol 0 when the accepted symbol before it was also 0.
- R4: Matches overlap. In 2-1-0-0, detect is high on both zeros. In 0-0-0, detect is high on the second and third zeros.
- R5: An accepted symbol 2 restarts the long pattern from any state, so 2-2-1-0 and 0-2-1-0 both detect on the final 0.
- R6: An accepted symbol 1 that does not directly follow a 2 clears the history, so 0-1-0 and 2-1-1-0 give no detection.
- R7: Symbol code binary 11 is illegal. It never asserts detect and clears the history, so 0-(11)-0 and 2-1-(11)-0 give no detection. The legal codes are 00, 01 and 10, meaning symbols 0, 1 and 2.
- R8: While valid is low, detect is low and the history is held, so 2-1-(gap)-0 and 0-(gap)-0 still detect on the final 0.
- R9: Detect is never high unless valid is high and the symbol is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| symValid | input | 1 | High when symIn carries a symbol to accept |
| symIn | input | SYM_W (2) | Symbol code: 00 = 0, 01 = 1, 10 = 2, 11 = illegal |
| detect | output | 1 | High in the cycle of a symbol that completes a match |

## Verification
The bench builds the block with its default two-bit symbol width. At that width all four codes can be driven, including the single illegal one, so every code can be applied in every one of the four states. Directed sequences cover the overlap, restart, clearing, illegal-code and gap cases. A long pseudo-random stream, with a random valid strobe and all four codes, then exercises state and code pairs that the directed cases do not order in the same way.

// File: rtl/tsr_pkg.sv
package tsr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_ZERO    = 2'd1,
    ST_TWO     = 2'd2,
    ST_TWO_ONE = 2'd3
  } seqState_t;

  typedef struct packed {
    logic isZero;
    logic isOne;
    logic isTwo;
    logic isBad;
  } symClass_t;

  typedef struct packed {
    logic shortHit;
    logic longHit;
  } hitStrobe_t;

endpackage

// File: rtl/tsrSymbolDecode.sv
module tsrSymbolDecode
  import tsr_pkg::*;
#(
  parameter int SYM_W = 2
) (
  input  logic             symValid,
  input  logic [SYM_W-1:0] symIn,
  output symClass_t        cls
);
  localparam logic [SYM_W-1:0] CODE_ZERO = SYM_W'(0);
  localparam logic [SYM_W-1:0] CODE_ONE  = SYM_W'(1);
  localparam logic [SYM_W-1:0] CODE_TWO  = SYM_W'(2);

  always_comb begin
    cls        = '0;
    if (symValid) begin
      cls.isZero = (symIn == CODE_ZERO);
      cls.isOne  = (symIn == CODE_ONE);
      cls.isTwo  = (symIn == CODE_TWO);
      cls.isBad  = (symIn > CODE_TWO);
    end
  end
endmodule

// File: rtl/tsrSeqControl.sv
module tsrSeqControl
  import tsr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  symClass_t  cls,
  output hitStrobe_t hits
);
  seqState_t curState;
  seqState_t nextState;

  always_comb begin
    nextState = curState;
    hits      = '0;
    if (cls.isZero) begin
      nextState     = ST_ZERO;
      hits.shortHit = (curState == ST_ZERO);
      hits.longHit  = (curState == ST_TWO_ONE);
    end else if (cls.isOne) begin
      nextState = (curState == ST_TWO) ? ST_TWO_ONE : ST_IDLE;
    end else if (cls.isTwo) begin
      nextState = ST_TWO;
    end else if (cls.isBad) begin
      nextState = ST_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) curState <= ST_IDLE;
    else     curState <= nextState;
  end
endmodule

// File: rtl/tsrDetectPath.sv
module tsrDetectPath
  import tsr_pkg::*;
(
  input  logic       rst,
  input  hitStrobe_t hits,
  output logic       detect
);
  always_comb detect = !rst && (hits.shortHit || hits.longHit);
endmodule

// File: rtl/ternary_seq_detector.sv
module ternary_seq_detector
  import tsr_pkg::*;
#(
  parameter int SYM_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             symValid,
  input  logic [SYM_W-1:0] symIn,
  output logic             detect
);
  symClass_t  cls;
  hitStrobe_t hits;

  tsrSymbolDecode #(.SYM_W(SYM_W)) u_decode (
    .symValid(symValid),
    .symIn   (symIn),
    .cls     (cls)
  );

  tsrSeqControl u_ctrl (
    .clk (clk),
    .rst (rst),
    .cls (cls),
    .hits(hits)
  );

  tsrDetectPath u_path (
    .rst   (rst),
    .hits  (hits),
    .detect(detect)
  );
endmodule

// File: rtl/tsrSeqChecker.sv
module tsrSeqChecker #(
  parameter int SYM_W = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             symValid,
  input logic [SYM_W-1:0] symIn,
  input logic             detect
);
  logic isZero, isOne, isTwo, isBad;
  assign isZero = symValid && (symIn == SYM_W'(0));
  assign isOne  = symValid && (symIn == SYM_W'(1));
  assign isTwo  = symValid && (symIn == SYM_W'(2));
  assign isBad  = symValid && (symIn > SYM_W'(2));

  // R1
  p_reset_quiet_r1: assert property (@(posedge clk) rst |-> !detect);

  p_long_match_r2: assert property (@(posedge clk) disable iff (rst)
    isTwo ##1 isOne ##1 isZero |-> detect);

  p_short_match_r3: assert property (@(posedge clk) disable iff (rst)
    isZero ##1 isZero |-> detect);

  p_bad_silent_r7: assert property (@(posedge clk) disable iff (rst)
    isBad |-> !detect);

  p_bad_clears_r7: assert property (@(posedge clk) disable iff (rst)
    isBad ##1 isZero |-> !detect);

  p_gap_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !symValid |-> !detect);

  p_detect_on_zero_r9: assert property (@(posedge clk) disable iff (rst)
    detect |-> isZero);
endmodule

bind ternary_seq_detector tsrSeqChecker #(.SYM_W(SYM_W)) u_checker (
  .clk     (clk),
  .rst     (rst),
  .symValid(symValid),
  .symIn   (symIn),
  .detect  (detect)
);

// File: tb/ternary_seq_detector_test.sv
`timescale 1ns/1ps
module ternary_seq_detector_test;
  localparam int SYM_W = 2;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             symValid = 1'b0;
  logic [SYM_W-1:0] symIn = '0;
  logic             detect;

  int checks = 0;
  int fails  = 0;
  int hist[$];

  always #2 clk = ~clk;

  ternary_seq_detector #(.SYM_W(SYM_W)) uut (
    .clk(clk), .rst(rst), .symValid(symValid), .symIn(symIn), .detect(detect)
  );

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: run did not finish, got hung, expected completion");
    report();
  end

  function automatic logic modelDetect(logic v, int s);
    if (!v || s != 0 || hist.size() == 0) return 1'b0;
    if (hist[$] == 0) return 1'b1;
    if (hist.size() >= 2 && hist[$-1] == 2 && hist[$] == 1) return 1'b1;
    return 1'b0;
  endfunction

  task automatic step(input logic v, input int s, input string tag);
    logic expD;
    @(negedge clk);
    symValid = v;
    symIn    = SYM_W'(s);
    #1;
    expD = modelDetect(v, s);
    checks++;
    if (detect !== expD) begin
      fails++;
      $display("FAIL %s: valid=%0b sym=%0d detect=%0b expected=%0b", tag, v, s, detect, expD);
    end
    @(posedge clk);
    if (v) begin
      if (s > 2) hist.delete();
      else begin
        hist.push_back(s);
        if (hist.size() > 2) void'(hist.pop_front());
      end
    end
  endtask

  task automatic seq(input int a[], input string tag);
    foreach (a[i]) begin
      if (a[i] < 0) step(1'b0, 0, tag);
      else          step(1'b1, a[i], tag);
    end
    step(1'b1, 3, tag);
  endtask

  initial begin
    repeat (3) begin
      @(negedge clk);
      symValid = 1'b1;
      symIn    = '0;
      #1;
      checks++;
      if (detect !== 1'b0) begin
        fails++;
        $display("FAIL R1: detect=%0b during reset, expected=0", detect);
      end
    end
    @(negedge clk);
    rst = 1'b0;
    symValid = 1'b0;
    hist.delete();
    seq('{0}, "R1");
    seq('{2, 1, 0}, "R2");
    seq('{0, 0}, "R3");
    seq('{2, 1, 0, 0}, "R4");
    seq('{0, 0, 0}, "R4");
    seq('{2, 2, 1, 0}, "R5");
    seq('{0, 2, 1, 0}, "R5");
    seq('{0, 1, 0}, "R6");
    seq('{2, 1, 1, 0}, "R6");
    seq('{0, 3, 0}, "R7");
    seq('{2, 1, 3, 0}, "R7");
    seq('{2, 1, -1, -1, 0}, "R8");
    seq('{0, -1, 0}, "R8");
    seq('{1, 2, 0, 2, 1, 2, 1, 0}, "R9");
    for (int i = 0; i < 2000; i++) begin
      logic v;
      v = ($urandom % 4) != 0;
      step(v, int'($urandom % 4), "R9");
    end
    report();
  end
endmodule